// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the configuration and state store of an interrupt distributor. Software reaches it over a simple 32-bit register bus with per-byte write enables. It holds, for each implemented interrupt line, an enable bit, a pending bit, a group bit, an 8-bit priority and an 8-bit core mask. It also holds a global forwarding enable for each of the two groups. The number of lines is a parameter. It is a multiple of 32 and at most 1024. Every configuration value and every pending flag leaves the block as a flat vector, for a downstream arbiter to use.

Enable and pending state are changed through paired windows. One window sets bits when 1 is written to them. The other clears bits when 1 is written to them. Writing 0 changes nothing. Bits of lines that do not exist always read back as 0, so software can find the number of lines by writing all ones and then looking for the highest bit that reads back as 1. IDs 0..15 are software-generated. Their pending state is kept separately for each core, and only a packed trigger word can raise it. IDs 16 and above become pending on a rising edge of their input or through the set-pending window. A per-core acknowledge port clears pending state.

Top module: `distRegBank`

## Requirements
- R1: After reset, all enable, pending, group, priority, target, per-core software-interrupt and global-enable state is 0, and every register reads 0.
- R2: At byte offset 0x000, bit 0 is the group-0 forwarding enable and bit 1 is the group-1 forwarding enable. The register is written only when busBe[0] is set. The two bits drive grpEnable[1:0]. Offset 0x004 is read-only and returns NUM_IRQ/32-1 in bits [4:0].
- R3: Set-enable is the window at 0x100+4n and clear-enable is the window at 0x180+4n. Line i is bit i%32 of word n=i/32. Writing 1 to a bit sets or clears that enable, and writing 0 changes nothing. busBe[k] gates bits [8k+7:8k]. Both windows read back the current enable bits, and enableVec[i] is the enable bit of line i.
- R4: A bit, byte or word that belongs to a line number at or above NUM_IRQ reads 0, even after all ones has been written to it. This holds in every window.
- R5: Set-pending is the window at 0x200+4n and clear-pending is the window at 0x280+4n. They use the same write-one and byte-lane rules as R3, but only for IDs 16 and above. Bits for IDs 0..15 in these windows are ignored.
- R6: For IDs 0..15, the pending bit that is read back and shown on pendingVec is the OR, over all cores, of that ID's per-core software-interrupt pending bits.
- R7: Each line has one priority byte, at byte offset 0x400+i. A write with a single byte enable changes only that line's byte.
- R8: Each line has an 8-bit core mask. The mask of line i is bits [(i%4)*8+7:(i%4)*8] of the word at 0x800+4*(i/4). Each byte is written through its own byte lane.
- R9: The group bits are read/write at 0x080+4n, with byte-lane gating. They appear on groupVec.
- R10: A write to 0xF00 takes the ID from bits [3:0], a group bit from bit 15 and a core list from bits [23:16]. If bit 15 equals the group bit of that ID, the block sets the pending bit of that ID for each listed core below NUM_CORES. If the two differ, the write has no effect. The bit for ID s and core c is sgiPendFlat[s*NUM_CORES+c].
- R11: A rising edge on irqIn[i] (i >= 16) sets pending for line i. A level that stays high does not set it again after it has been cleared.
- R12: When ackValid is high, the acknowledge port clears the pending bit of ackId, or, for ackId < 16, the pending bit of ackId for core ackCore. An ackId at or above NUM_IRQ is ignored. If a set and a clear reach the same bit in the same cycle, the set wins.
- R13: busRdata shows the addressed word combinationally while busSel is high and busWrite is low. Any offset not named here reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 10 | Word address (byte offset / 4) |
| busWdata | input | 32 | Write data |
| busBe | input | 4 | Byte-lane write enables |
| busRdata | output | 32 | Read data, same cycle |
| irqIn | input | NUM_IRQ-16 | Raw interrupt inputs for IDs 16..NUM_IRQ-1 |
| ackValid | input | 1 | Acknowledge strobe |
| ackId | input | 10 | Acknowledged ID |
| ackCore | input | 3 | Core that acknowledges |
| enableVec | output | NUM_IRQ | Per-line enable |
| pendingVec | output | NUM_IRQ | Per-line pending |
| groupVec | output | NUM_IRQ | Per-line group |
| priorityFlat | output | NUM_IRQ*8 | Priority byte i at [8i+7:8i] |
| targetFlat | output | NUM_IRQ*8 | Core mask of line i at [8i+7:8i] |
| grpEnable | output | 2 | Global forwarding enable per group |
| sgiPendFlat | output | 16*NUM_CORES | Per-core software-interrupt pending |

## Verification
The enable windows are tested with all-ones probes, with sparse clear masks and with partial byte lanes. These separate the correct write-one behaviour from a plain overwrite, and they show whether lines that do not exist stay at 0. The pending state is driven from four sources: the windows, trigger words with a matching and with a mismatching group bit, input edges (including a level held high across an acknowledge), and an acknowledge that arrives in the same cycle as a set. Each source can only be seen working through its own result. Single-lane priority and target writes next to full-word writes show whether lanes leak into the neighbouring bytes.

// File: rtl/distRegPkg.sv
package distRegPkg;

  localparam int REG_BITS  = 32;
  localparam int SGI_COUNT = 16;
  localparam int ID_W      = 10;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTRL, RD_TYPE, RD_GROUP, RD_EN, RD_PEND, RD_PRIO, RD_TGT
  } rdSel_e;

  // strobes from the decoder to the state datapath
  typedef struct packed {
    logic       wrCtrl;
    logic       wrGroup;
    logic       wrSetEn;
    logic       wrClrEn;
    logic       wrSetPend;
    logic       wrClrPend;
    logic       wrPrio;
    logic       wrTgt;
    logic       wrSgi;
    rdSel_e     rdSel;
    logic [7:0] regIdx;
  } distStrobe_t;

endpackage

// File: rtl/distDecode.sv
module distDecode
  import distRegPkg::*;
(
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [9:0]  busAddr,
  output distStrobe_t stb
);

  logic wr;
  logic rd;
  assign wr = busSel & busWrite;
  assign rd = busSel & ~busWrite;

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    if (busAddr == 10'h000) begin
      stb.wrCtrl = wr;
      if (rd) stb.rdSel = RD_CTRL;
    end else if (busAddr == 10'h001) begin
      if (rd) stb.rdSel = RD_TYPE;
    end else if (busAddr == 10'h3C0) begin
      stb.wrSgi = wr;
    end else if (busAddr[9:8] == 2'd1) begin
      stb.regIdx = busAddr[7:0];
      stb.wrPrio = wr;
      if (rd) stb.rdSel = RD_PRIO;
    end else if (busAddr[9:8] == 2'd2) begin
      stb.regIdx = busAddr[7:0];
      stb.wrTgt  = wr;
      if (rd) stb.rdSel = RD_TGT;
    end else begin
      stb.regIdx = {3'b000, busAddr[4:0]};
      case (busAddr[9:5])
        5'd1: begin stb.wrGroup   = wr; if (rd) stb.rdSel = RD_GROUP; end
        5'd2: begin stb.wrSetEn   = wr; if (rd) stb.rdSel = RD_EN;    end
        5'd3: begin stb.wrClrEn   = wr; if (rd) stb.rdSel = RD_EN;    end
        5'd4: begin stb.wrSetPend = wr; if (rd) stb.rdSel = RD_PEND;  end
        5'd5: begin stb.wrClrPend = wr; if (rd) stb.rdSel = RD_PEND;  end
        default: stb.regIdx = '0;
      endcase
    end
  end

endmodule

// File: rtl/distState.sv
module distState
  import distRegPkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_CORES = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  distStrobe_t                   stb,
  input  logic [31:0]                   busWdata,
  input  logic [3:0]                    busBe,
  output logic [31:0]                   busRdata,
  input  logic [NUM_IRQ-1:SGI_COUNT]    irqIn,
  input  logic                          ackValid,
  input  logic [ID_W-1:0]               ackId,
  input  logic [2:0]                    ackCore,
  output logic [NUM_IRQ-1:0]            enableVec,
  output logic [NUM_IRQ-1:0]            pendingVec,
  output logic [NUM_IRQ-1:0]            groupVec,
  output logic [NUM_IRQ*8-1:0]          priorityFlat,
  output logic [NUM_IRQ*8-1:0]          targetFlat,
  output logic [1:0]                    grpEnable,
  output logic [SGI_COUNT*NUM_CORES-1:0] sgiPendFlat
);

  localparam int NUM_REGS = NUM_IRQ / REG_BITS;
  localparam int SGI_BITS = SGI_COUNT * NUM_CORES;

  logic [NUM_IRQ-1:0]          enReg, enSet, enClr, grpReg, grpNext;
  logic [NUM_IRQ-1:SGI_COUNT]  pendReg, pendSet, pendClr, irqPrev;
  logic [SGI_BITS-1:0]         sgiPend, sgiSet, sgiClr;
  logic [NUM_IRQ-1:0][7:0]     prioArr, tgtArr;
  logic [1:0]                  ctlReg;
  logic [31:0]                 laneMask, wMasked;

  assign laneMask = {{8{busBe[3]}}, {8{busBe[2]}}, {8{busBe[1]}}, {8{busBe[0]}}};
  assign wMasked  = busWdata & laneMask;

  // set/clear terms for every bit of state
  always_comb begin
    enSet   = '0;
    enClr   = '0;
    grpNext = grpReg;
    pendSet = irqIn & ~irqPrev;
    pendClr = '0;
    sgiSet  = '0;
    sgiClr  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (stb.regIdx == 8'(i / REG_BITS)) begin
        if (stb.wrSetEn) enSet[i] = wMasked[i % REG_BITS];
        if (stb.wrClrEn) enClr[i] = wMasked[i % REG_BITS];
        if (stb.wrGroup && laneMask[i % REG_BITS]) grpNext[i] = busWdata[i % REG_BITS];
      end
    end
    for (int i = SGI_COUNT; i < NUM_IRQ; i++) begin
      if (stb.regIdx == 8'(i / REG_BITS)) begin
        if (stb.wrSetPend) pendSet[i] = pendSet[i] | wMasked[i % REG_BITS];
        if (stb.wrClrPend) pendClr[i] = wMasked[i % REG_BITS];
      end
      if (ackValid && 32'(ackId) == i) pendClr[i] = 1'b1;
    end
    for (int s = 0; s < SGI_COUNT; s++) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        if (stb.wrSgi && busWdata[3:0] == 4'(s) && busWdata[16+c] && busWdata[15] == grpReg[s])
          sgiSet[s*NUM_CORES+c] = 1'b1;
        if (ackValid && ackId == ID_W'(s) && ackCore == 3'(c))
          sgiClr[s*NUM_CORES+c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= '0;
      pendReg <= '0;
      irqPrev <= '0;
      sgiPend <= '0;
      grpReg  <= '0;
      ctlReg  <= '0;
      prioArr <= '0;
      tgtArr  <= '0;
    end else begin
      enReg   <= (enReg & ~enClr) | enSet;
      pendReg <= (pendReg & ~pendClr) | pendSet;   // set wins
      sgiPend <= (sgiPend & ~sgiClr) | sgiSet;     // set wins
      irqPrev <= irqIn;
      grpReg  <= grpNext;
      if (stb.wrCtrl && busBe[0]) ctlReg <= busWdata[1:0];
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (stb.regIdx == 8'(i / 4) && busBe[i % 4]) begin
          if (stb.wrPrio) prioArr[i] <= busWdata[(i % 4)*8 +: 8];
          if (stb.wrTgt)  tgtArr[i]  <= busWdata[(i % 4)*8 +: 8];
        end
      end
    end
  end

  generate
    for (genvar s = 0; s < SGI_COUNT; s++) begin : g_sgiOr
      assign pendingVec[s] = |sgiPend[s*NUM_CORES +: NUM_CORES];
    end
  endgenerate
  assign pendingVec[NUM_IRQ-1:SGI_COUNT] = pendReg;

  assign enableVec    = enReg;
  assign groupVec     = grpReg;
  assign priorityFlat = prioArr;
  assign targetFlat   = tgtArr;
  assign grpEnable    = ctlReg;
  assign sgiPendFlat  = sgiPend;

  // read mux
  always_comb begin
    busRdata = '0;
    case (stb.rdSel)
      RD_CTRL: busRdata[1:0] = ctlReg;
      RD_TYPE: busRdata[4:0] = 5'(NUM_REGS - 1);
      RD_GROUP, RD_EN, RD_PEND: begin
        for (int i = 0; i < NUM_IRQ; i++) begin
          if (stb.regIdx == 8'(i / REG_BITS)) begin
            if (stb.rdSel == RD_GROUP)   busRdata[i % REG_BITS] = grpReg[i];
            else if (stb.rdSel == RD_EN) busRdata[i % REG_BITS] = enReg[i];
            else                         busRdata[i % REG_BITS] = pendingVec[i];
          end
        end
      end
      RD_PRIO, RD_TGT: begin
        for (int i = 0; i < NUM_IRQ; i++) begin
          if (stb.regIdx == 8'(i / 4))
            busRdata[(i % 4)*8 +: 8] = (stb.rdSel == RD_PRIO) ? prioArr[i] : tgtArr[i];
        end
      end
      default: busRdata = '0;
    endcase
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCtrl && busBe[0]) |=> grpEnable == $past(busWdata[1:0])); // R2

  AST_HIGH_EN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSel == RD_EN && stb.regIdx >= 8'(NUM_REGS)) |-> busRdata == '0); // R4

  AST_LOW_PEND_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.wrSetPend || stb.wrClrPend) && !ackValid) |=> $stable(pendingVec[SGI_COUNT-1:0])); // R5

  AST_SGI_GROUP_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSgi && busWdata[15] != groupVec[busWdata[3:0]] && !ackValid) |=> $stable(sgiPendFlat)); // R10

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && 32'(ackId) >= SGI_COUNT && 32'(ackId) < NUM_IRQ && !stb.wrSetPend
     && (irqIn & ~irqPrev) == '0) |=> !pendingVec[$past(ackId)]); // R12

endmodule

// File: rtl/distRegBank.sv
module distRegBank
  import distRegPkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_CORES = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busSel,
  input  logic                           busWrite,
  input  logic [9:0]                     busAddr,
  input  logic [31:0]                    busWdata,
  input  logic [3:0]                     busBe,
  output logic [31:0]                    busRdata,
  input  logic [NUM_IRQ-1:16]            irqIn,
  input  logic                           ackValid,
  input  logic [9:0]                     ackId,
  input  logic [2:0]                     ackCore,
  output logic [NUM_IRQ-1:0]             enableVec,
  output logic [NUM_IRQ-1:0]             pendingVec,
  output logic [NUM_IRQ-1:0]             groupVec,
  output logic [NUM_IRQ*8-1:0]           priorityFlat,
  output logic [NUM_IRQ*8-1:0]           targetFlat,
  output logic [1:0]                     grpEnable,
  output logic [16*NUM_CORES-1:0]        sgiPendFlat
);

  distStrobe_t stb;

  distDecode u_decode (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .stb     (stb)
  );

  distState #(.NUM_IRQ(NUM_IRQ), .NUM_CORES(NUM_CORES)) u_state (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .busWdata    (busWdata),
    .busBe       (busBe),
    .busRdata    (busRdata),
    .irqIn       (irqIn),
    .ackValid    (ackValid),
    .ackId       (ackId),
    .ackCore     (ackCore),
    .enableVec   (enableVec),
    .pendingVec  (pendingVec),
    .groupVec    (groupVec),
    .priorityFlat(priorityFlat),
    .targetFlat  (targetFlat),
    .grpEnable   (grpEnable),
    .sgiPendFlat (sgiPendFlat)
  );

endmodule

// File: tb/tb_distRegBank.sv
`timescale 1ns/1ps
module tb_distRegBank;

  localparam int NI = 64;
  localparam int NC = 8;

  logic clk = 0;
  logic rstN = 0;
  logic busSel = 0, busWrite = 0;
  logic [9:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0] busBe = '0;
  logic [31:0] busRdata;
  logic [NI-1:16] irqIn = '0;
  logic ackValid = 0;
  logic [9:0] ackId = '0;
  logic [2:0] ackCore = '0;
  logic [NI-1:0] enableVec, pendingVec, groupVec;
  logic [NI*8-1:0] priorityFlat, targetFlat;
  logic [1:0] grpEnable;
  logic [16*NC-1:0] sgiPendFlat;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  distRegBank #(.NUM_IRQ(NI), .NUM_CORES(NC)) dut (.*);

  // ---------------- behavioural reference model ----------------
  bit       mEn[NI], mPend[NI], mGrp[NI], mPrev[NI];
  bit [7:0] mPrio[NI], mTgt[NI];
  bit       mSgi[16][NC];
  bit [1:0] mCtl;

  function automatic bit [31:0] mRead(int off);
    bit [31:0] r = 0;
    if (off == 0) r = {30'b0, mCtl};
    else if (off == 4) r = NI/32 - 1;
    else if (off >= 'h80 && off < 'h300) begin
      int n = ((off - 'h80) % 'h80) / 4;
      for (int b = 0; b < 32; b++) begin
        int id = n*32 + b;
        if (id < NI) begin
          if (off < 'h100) r[b] = mGrp[id];
          else if (off < 'h200) r[b] = mEn[id];
          else if (id < 16) begin
            for (int c = 0; c < NC; c++) r[b] = r[b] | mSgi[id][c];
          end else r[b] = mPend[id];
        end
      end
    end else if (off >= 'h400 && off < 'hC00) begin
      int base = (off >= 'h800) ? off - 'h800 : off - 'h400;
      for (int k = 0; k < 4; k++)
        if (base + k < NI) r[k*8 +: 8] = (off >= 'h800) ? mTgt[base+k] : mPrio[base+k];
    end
    return r;
  endfunction

  task automatic modelStep();
    int off = int'(busAddr) * 4;
    bit wr = busSel && busWrite;
    bit [31:0] lm = {{8{busBe[3]}}, {8{busBe[2]}}, {8{busBe[1]}}, {8{busBe[0]}}};
    bit [31:0] wd = busWdata & lm;
    // clears first so that sets win
    if (ackValid) begin
      if (ackId < 16) begin
        if (ackCore < NC) mSgi[ackId][ackCore] = 0;
      end else if (ackId < NI) mPend[ackId] = 0;
    end
    if (wr) begin
      if (off == 0 && busBe[0]) mCtl = busWdata[1:0];
      for (int b = 0; b < 32; b++) begin
        int n = ((off - 'h80) % 'h80) / 4;
        int id = n*32 + b;
        if (id < NI && off >= 'h80) begin
          if (off < 'h100 && lm[b]) mGrp[id] = busWdata[b];
          else if (off >= 'h180 && off < 'h200 && wd[b]) mEn[id] = 0;
          else if (off >= 'h280 && off < 'h300 && wd[b] && id >= 16) mPend[id] = 0;
        end
      end
    end
    for (int i = 16; i < NI; i++) if (irqIn[i] && !mPrev[i]) mPend[i] = 1;
    if (wr) begin
      for (int b = 0; b < 32; b++) begin
        int n = ((off - 'h80) % 'h80) / 4;
        int id = n*32 + b;
        if (id < NI && off >= 'h100) begin
          if (off < 'h180 && wd[b]) mEn[id] = 1;
          else if (off >= 'h200 && off < 'h280 && wd[b] && id >= 16) mPend[id] = 1;
        end
      end
      if (off >= 'h400 && off < 'hC00) begin
        int base = (off >= 'h800) ? off - 'h800 : off - 'h400;
        for (int k = 0; k < 4; k++)
          if (base + k < NI && busBe[k]) begin
            if (off >= 'h800) mTgt[base+k] = busWdata[k*8 +: 8];
            else mPrio[base+k] = busWdata[k*8 +: 8];
          end
      end
      if (off == 'hF00 && busWdata[15] == mGrp[busWdata[3:0]])
        for (int c = 0; c < NC; c++) if (busWdata[16+c]) mSgi[busWdata[3:0]][c] = 1;
    end
    for (int i = 16; i < NI; i++) mPrev[i] = irqIn[i];
  endtask

  task automatic chk(bit ok, string tag, logic [1023:0] got, logic [1023:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // update on every edge, compare just after it
  always @(posedge clk) begin
    logic [NI-1:0] eEn, ePend, eGrp;
    logic [NI*8-1:0] ePrio, eTgt;
    logic [16*NC-1:0] eSgi;
    if (rstN) modelStep();
    #1;
    for (int i = 0; i < NI; i++) begin
      eEn[i] = mEn[i]; eGrp[i] = mGrp[i];
      ePrio[i*8 +: 8] = mPrio[i]; eTgt[i*8 +: 8] = mTgt[i];
      ePend[i] = (i >= 16) ? mPend[i] : 1'b0;
    end
    for (int s = 0; s < 16; s++)
      for (int c = 0; c < NC; c++) begin
        eSgi[s*NC+c] = mSgi[s][c];
        if (mSgi[s][c]) ePend[s] = 1'b1;
      end
    chk(enableVec == eEn, "R3 enableVec", 1024'(enableVec), 1024'(eEn));
    chk(pendingVec == ePend, "R5 pendingVec", 1024'(pendingVec), 1024'(ePend));
    chk(groupVec == eGrp, "R9 groupVec", 1024'(groupVec), 1024'(eGrp));
    chk(priorityFlat == ePrio, "R7 priorityFlat", 1024'(priorityFlat), 1024'(ePrio));
    chk(targetFlat == eTgt, "R8 targetFlat", 1024'(targetFlat), 1024'(eTgt));
    chk(grpEnable == mCtl, "R2 grpEnable", 1024'(grpEnable), 1024'(mCtl));
    chk(sgiPendFlat == eSgi, "R10 sgiPendFlat", 1024'(sgiPendFlat), 1024'(eSgi));
    if (busSel && !busWrite)
      chk(busRdata == mRead(int'(busAddr)*4), "R13 busRdata",
          1024'(busRdata), 1024'(mRead(int'(busAddr)*4)));
  end

  // ---------------- stimulus helpers ----------------
  task automatic busWr(int off, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 10'(off >> 2); busWdata = d; busBe = be;
    @(negedge clk);
    busSel = 0; busWrite = 0; busBe = '0;
  endtask

  task automatic rdCheck(int off, logic [31:0] exp, string tag);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = 10'(off >> 2);
    #1;
    chk(busRdata == exp, tag, 1024'(busRdata), 1024'(exp));
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic ackPulse(int id, int core);
    @(negedge clk);
    ackValid = 1; ackId = 10'(id); ackCore = 3'(core);
    @(negedge clk);
    ackValid = 0;
  endtask

  initial begin
    logic [NI-1:0] snap;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pendingVec == '0 && enableVec == '0 && grpEnable == '0, "R1 reset outputs",
        1024'({pendingVec, enableVec}), 1024'(0));
    rstN = 1;
    rdCheck('h000, 32'h0, "R1 ctrl after reset");
    rdCheck('h100, 32'h0, "R1 enable after reset");

    // R2 control and type
    rdCheck('h004, 32'(NI/32 - 1), "R2 type register");
    busWr('h000, 32'h3, 4'b0001);
    chk(grpEnable == 2'b11, "R2 grpEnable set", 1024'(grpEnable), 1024'(3));
    busWr('h000, 32'h0, 4'b0000);
    chk(grpEnable == 2'b11, "R2 lane 0 off ignored", 1024'(grpEnable), 1024'(3));
    busWr('h000, 32'h2, 4'b0001);
    rdCheck('h000, 32'h2, "R2 ctrl readback");

    // R3 / R4 enable probing
    busWr('h100, 32'hFFFF_FFFF, 4'hF);
    busWr('h104, 32'hFFFF_FFFF, 4'hF);
    busWr('h108, 32'hFFFF_FFFF, 4'hF);
    rdCheck('h104, 32'hFFFF_FFFF, "R4 highest implemented word");
    rdCheck('h108, 32'h0, "R4 unimplemented set-enable word");
    rdCheck('h188, 32'h0, "R4 unimplemented clear-enable word");
    busWr('h180, 32'h0000_00F0, 4'hF);
    rdCheck('h100, 32'hFFFF_FF0F, "R3 clear-enable write-one");
    busWr('h184, 32'hFFFF_FFFF, 4'b0010);
    rdCheck('h184, 32'hFFFF_00FF, "R3 byte-lane clear");

    // R5 pending windows
    busWr('h200, 32'hFFFF_FFFF, 4'hF);
    rdCheck('h200, 32'hFFFF_0000, "R5 low IDs ignored in set-pending");
    busWr('h280, 32'h000F_0000, 4'hF);
    rdCheck('h280, 32'hFFF0_0000, "R5 clear-pending");
    busWr('h204, 32'h1, 4'hF);
    chk(pendingVec[32] == 1'b1, "R5 pending id 32", 1024'(pendingVec[32]), 1024'(1));

    // R9 group bits
    busWr('h080, 32'h0000_FF00, 4'hF);
    chk(groupVec[15:0] == 16'hFF00, "R9 groupVec", 1024'(groupVec[15:0]), 1024'(16'hFF00));
    busWr('h084, 32'hA5A5_A5A5, 4'b1001);
    rdCheck('h084, 32'hA500_00A5, "R9 group byte lanes");

    // R10 trigger word, R6 read-back of low IDs
    busWr('hF00, 32'h0005_8009, 4'hF);
    rdCheck('h200, 32'hFFF0_0200, "R6 SGI pending OR in window");
    chk(sgiPendFlat[9*NC +: NC] == 8'h05, "R10 per-core set",
        1024'(sgiPendFlat[9*NC +: NC]), 1024'(5));
    busWr('hF00, 32'h0001_8003, 4'hF);
    chk(sgiPendFlat[3*NC +: NC] == 8'h00, "R10 group mismatch ignored",
        1024'(sgiPendFlat[3*NC +: NC]), 1024'(0));
    busWr('hF00, 32'h0080_0003, 4'hF);
    chk(pendingVec[3] == 1'b1, "R6 id 3 pending from core 7", 1024'(pendingVec[3]), 1024'(1));

    // R12 acknowledge
    ackPulse(9, 0);
    chk(pendingVec[9] == 1'b1, "R12 other core still pending", 1024'(pendingVec[9]), 1024'(1));
    ackPulse(9, 2);
    chk(pendingVec[9] == 1'b0, "R12 last core cleared", 1024'(pendingVec[9]), 1024'(0));
    ackPulse(20, 0);
    chk(pendingVec[20] == 1'b0, "R12 ack clears id 20", 1024'(pendingVec[20]), 1024'(0));
    snap = pendingVec;
    ackPulse(100, 0);
    chk(pendingVec == snap, "R12 out-of-range ack ignored", 1024'(pendingVec), 1024'(snap));
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 10'('h200 >> 2); busWdata = 32'h0010_0000; busBe = 4'hF;
    ackValid = 1; ackId = 10'd20;
    @(negedge clk);
    busSel = 0; busWrite = 0; busBe = '0; ackValid = 0;
    chk(pendingVec[20] == 1'b1, "R12 set wins over ack", 1024'(pendingVec[20]), 1024'(1));

    // R11 input edges
    @(negedge clk); irqIn[40] = 1;
    @(negedge clk);
    chk(pendingVec[40] == 1'b1, "R11 rising edge", 1024'(pendingVec[40]), 1024'(1));
    ackPulse(40, 0);
    repeat (3) @(negedge clk);
    chk(pendingVec[40] == 1'b0, "R11 held level no re-set", 1024'(pendingVec[40]), 1024'(0));
    irqIn[40] = 0;
    @(negedge clk); irqIn[40] = 1;
    @(negedge clk);
    chk(pendingVec[40] == 1'b1, "R11 second edge", 1024'(pendingVec[40]), 1024'(1));

    // R7 priority bytes
    busWr('h414, 32'h1122_3344, 4'hF);
    busWr('h414, 32'h00AA_0000, 4'b0100);
    rdCheck('h414, 32'h11AA_3344, "R7 single byte write");
    chk(priorityFlat[22*8 +: 8] == 8'hAA, "R7 priority id 22",
        1024'(priorityFlat[22*8 +: 8]), 1024'(8'hAA));
    busWr('h440, 32'hFFFF_FFFF, 4'hF);
    rdCheck('h440, 32'h0, "R4 unimplemented priority word");

    // R8 targets
    busWr('h81C, 32'h0403_0201, 4'hF);
    busWr('h81C, 32'h0000_00FF, 4'b0001);
    rdCheck('h81C, 32'h0403_02FF, "R8 target lanes");
    chk(targetFlat[31*8 +: 8] == 8'h04, "R8 target id 31",
        1024'(targetFlat[31*8 +: 8]), 1024'(4));

    // R13 unmapped offset
    busWr('hC00, 32'hFFFF_FFFF, 4'hF);
    rdCheck('hC00, 32'h0, "R13 unmapped offset");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule